// File: doc/BRIEF.md
# Completion Ring Index Manager

This block keeps the producer and consumer positions of two completion rings, one for received frames and one for sent frames. Both rings share a single 32-bit producer register and a single 32-bit consumer register: the receive ring uses the low 16 bits and the transmit ring uses the high 16 bits of each. The hardware side posts completion entries by pulsing one advance strobe for each ring. The host frees entries by writing the consumer register. A per-ring pending flag and a level interrupt tell the host that unread entries are waiting.

The block also holds the host's transmit buffer-descriptor producer position. The host writes this position as a count of 8-byte blocks in the upper half of its register. The block turns that count into a byte offset. It also keeps the byte offset of the descriptor that the next transmit completion refers to. The offset, not the ring index, is the form a completion entry carries, so software recovers the descriptor number by dividing the offset by the descriptor size in bytes.

Top module: `cq_index_mgr`

## Requirements
- R1: After a synchronous reset every index, the descriptor block count, the completion byte offset and the interrupt enables are zero, and both pending flags and the interrupt are low.
- R2: A cycle with `rx_post` high adds one to the receive producer, modulo `RXC_DEPTH`. A cycle with `tx_post` high adds one to the transmit producer, modulo `TXC_DEPTH`. When both strobes are high in the same cycle, both advances take effect. Each producer is read back in its half of register 0.
- R3: A post to a ring is dropped, and the producer keeps its value, when one more entry would make the producer equal the consumer (the ring is full).
- R4: A write to register 1 (consumer) loads the low half when `reg_wr_half[0]` is set and the high half when `reg_wr_half[1]` is set. A half that is not selected keeps its value. A loaded value is masked to its ring depth minus one.
- R5: A write to register 0 (producer) loads the selected halves, masked the same way. This write takes precedence over a post to the same ring in that cycle. Loading the high half also returns the completion byte offset to zero. Writing zero to both halves of registers 0 and 1 leaves both rings empty.
- R6: `rx_pending` is high exactly when the receive producer differs from the receive consumer. `tx_pending` is high exactly when the transmit producer differs from the transmit consumer.
- R7: `irq` = (`rx_pending` and enable bit 0) or (`tx_pending` and enable bit 1).
- R8: A write to register 2 takes the 8-byte block count from `reg_wdata[31:16]`, so descriptor i is written as i shifted left by 20. The count is masked to `TXD_DEPTH*TXD_BLOCKS-1` and the half enables are ignored. The register reads back as the count in bits 31:16 with bits 15:0 zero, and `txd_prod_offset` equals the count times 8.
- R9: `tx_cmp_offset` starts at zero. It grows by `TXD_BLOCKS*8` bytes for each transmit post that is accepted, and wraps to zero at `TXD_DEPTH*TXD_BLOCKS*8`.
- R10: `reg_rdata` is combinational on `reg_addr`: 0 gives {tx producer, rx producer}, 1 gives {tx consumer, rx consumer}, 2 gives the block count register, and 3 gives the two enable bits in bits 1:0. A write to register 3 loads `reg_wdata[1:0]` into the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_post | input | 1 | Receive completion entry posted |
| tx_post | input | 1 | Transmit completion entry posted |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wr_half | input | 2 | Half enables for registers 0 and 1 (bit 0 low, bit 1 high) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| rx_pending | output | 1 | Receive ring holds unread entries |
| tx_pending | output | 1 | Transmit ring holds unread entries |
| irq | output | 1 | Level interrupt |
| txd_prod_offset | output | 16 | Descriptor producer position in bytes |
| tx_cmp_offset | output | 16 | Byte offset of the descriptor for the next transmit completion |

## Verification
Every piece of state sits in one register stage. A post or a register write at a rising edge therefore shows up on `reg_rdata`, the pending flags, `irq` and both offsets right after that edge, one cycle after the stimulus was applied. `reg_rdata` itself follows `reg_addr` with no clock. The bench applies each stimulus at a falling edge and lets one rising edge pass. At the next falling edge it steps `reg_addr` through all four registers and compares every output against an arithmetic model. The model is advanced at that same rising edge, so each comparison is made exactly one cycle after its stimulus.

// File: rtl/cq_index_pkg.sv
package cq_index_pkg;

    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] idx_t;

    typedef enum logic [1:0] {
        CQ_REG_PROD = 2'd0,
        CQ_REG_CONS = 2'd1,
        CQ_REG_TXD  = 2'd2,
        CQ_REG_IEN  = 2'd3
    } cq_reg_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } half_sel_t;

    typedef struct packed {
        idx_t hi;
        idx_t lo;
    } split_word_t;

    function automatic idx_t wrap_inc(input idx_t v, input idx_t mask);
        return (v + idx_t'(1)) & mask;
    endfunction

    function automatic idx_t wrap_add(input idx_t v, input idx_t step, input idx_t mask);
        return (v + step) & mask;
    endfunction

endpackage

// File: rtl/cq_ring_ctr.sv
module cq_ring_ctr
    import cq_index_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic post,
    input  logic load_prod,
    input  idx_t prod_val,
    input  logic load_cons,
    input  idx_t cons_val,
    output idx_t prod,
    output idx_t cons,
    output logic pending,
    output logic advance
);

    localparam idx_t MASK = idx_t'(DEPTH - 1);

    idx_t prod_q;
    idx_t cons_q;
    idx_t prod_next;
    logic is_full;

    always_comb begin
        prod_next = wrap_inc(prod_q, MASK);
        is_full   = (prod_next == cons_q);
        advance   = post && !is_full && !load_prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
            cons_q <= '0;
        end else begin
            if (load_prod) begin
                prod_q <= prod_val & MASK;
            end else if (advance) begin
                prod_q <= prod_next;
            end
            if (load_cons) begin
                cons_q <= cons_val & MASK;
            end
        end
    end

    assign prod    = prod_q;
    assign cons    = cons_q;
    assign pending = (prod_q != cons_q);

endmodule

// File: rtl/cq_txd_pos.sv
module cq_txd_pos
    import cq_index_pkg::*;
#(
    parameter int TXD_DEPTH   = 8,
    parameter int TXD_BLOCKS  = 16,
    parameter int BLOCK_BYTES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load_blk,
    input  idx_t blk_val,
    input  logic clear_done,
    input  logic step_done,
    output idx_t blk,
    output idx_t prod_offset,
    output idx_t done_offset
);

    localparam int   BYTE_SHIFT = $clog2(BLOCK_BYTES);
    localparam idx_t BLK_MASK   = idx_t'(TXD_DEPTH * TXD_BLOCKS - 1);
    localparam idx_t DESC_BYTES = idx_t'(TXD_BLOCKS * BLOCK_BYTES);
    localparam idx_t OFF_MASK   = idx_t'(TXD_DEPTH * TXD_BLOCKS * BLOCK_BYTES - 1);

    idx_t blk_q;
    idx_t done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            done_q <= '0;
        end else begin
            if (load_blk) begin
                blk_q <= blk_val & BLK_MASK;
            end
            if (clear_done) begin
                done_q <= '0;
            end else if (step_done) begin
                done_q <= wrap_add(done_q, DESC_BYTES, OFF_MASK);
            end
        end
    end

    assign blk         = blk_q;
    assign prod_offset = blk_q << BYTE_SHIFT;
    assign done_offset = done_q;

endmodule

// File: rtl/cq_index_mgr.sv
module cq_index_mgr
    import cq_index_pkg::*;
#(
    parameter int RXC_DEPTH   = 16,
    parameter int TXC_DEPTH   = 8,
    parameter int TXD_DEPTH   = 8,
    parameter int TXD_BLOCKS  = 16,
    parameter int BLOCK_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_post,
    input  logic        tx_post,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [1:0]  reg_wr_half,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        rx_pending,
    output logic        tx_pending,
    output logic        irq,
    output logic [15:0] txd_prod_offset,
    output logic [15:0] tx_cmp_offset
);

    localparam int NUM_RINGS = 2;

    cq_reg_e     sel;
    half_sel_t   half;
    split_word_t wword;

    logic [NUM_RINGS-1:0] post_a;
    logic [NUM_RINGS-1:0] prod_ld;
    logic [NUM_RINGS-1:0] cons_ld;
    logic [NUM_RINGS-1:0] pend_a;
    logic [NUM_RINGS-1:0] adv_a;
    idx_t                 half_data [NUM_RINGS];
    idx_t                 prod_a    [NUM_RINGS];
    idx_t                 cons_a    [NUM_RINGS];

    logic [1:0] ien_q;
    idx_t       txd_blk;

    idx_t rx_prod;
    idx_t rx_cons;
    idx_t tx_prod;
    idx_t tx_cons;

    always_comb begin
        sel   = cq_reg_e'(reg_addr);
        half  = half_sel_t'(reg_wr_half);
        wword = split_word_t'(reg_wdata);
    end

    always_comb begin
        post_a[0]    = rx_post;
        post_a[1]    = tx_post;
        half_data[0] = wword.lo;
        half_data[1] = wword.hi;
        prod_ld[0]   = reg_wr_en && (sel == CQ_REG_PROD) && half.lo;
        prod_ld[1]   = reg_wr_en && (sel == CQ_REG_PROD) && half.hi;
        cons_ld[0]   = reg_wr_en && (sel == CQ_REG_CONS) && half.lo;
        cons_ld[1]   = reg_wr_en && (sel == CQ_REG_CONS) && half.hi;
    end

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        localparam int RING_DEPTH = (g == 0) ? RXC_DEPTH : TXC_DEPTH;
        cq_ring_ctr #(
            .DEPTH(RING_DEPTH)
        ) u_ring (
            .clk       (clk),
            .rst       (rst),
            .post      (post_a[g]),
            .load_prod (prod_ld[g]),
            .prod_val  (half_data[g]),
            .load_cons (cons_ld[g]),
            .cons_val  (half_data[g]),
            .prod      (prod_a[g]),
            .cons      (cons_a[g]),
            .pending   (pend_a[g]),
            .advance   (adv_a[g])
        );
    end

    cq_txd_pos #(
        .TXD_DEPTH   (TXD_DEPTH),
        .TXD_BLOCKS  (TXD_BLOCKS),
        .BLOCK_BYTES (BLOCK_BYTES)
    ) u_txd (
        .clk         (clk),
        .rst         (rst),
        .load_blk    (reg_wr_en && (sel == CQ_REG_TXD)),
        .blk_val     (wword.hi),
        .clear_done  (prod_ld[1]),
        .step_done   (adv_a[1]),
        .blk         (txd_blk),
        .prod_offset (txd_prod_offset),
        .done_offset (tx_cmp_offset)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (reg_wr_en && (sel == CQ_REG_IEN)) begin
            ien_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        rx_prod = prod_a[0];
        rx_cons = cons_a[0];
        tx_prod = prod_a[1];
        tx_cons = cons_a[1];
    end

    always_comb begin
        unique case (sel)
            CQ_REG_PROD: reg_rdata = {tx_prod, rx_prod};
            CQ_REG_CONS: reg_rdata = {tx_cons, rx_cons};
            CQ_REG_TXD:  reg_rdata = {txd_blk, idx_t'(0)};
            default:     reg_rdata = {30'd0, ien_q};
        endcase
    end

    assign rx_pending = pend_a[0];
    assign tx_pending = pend_a[1];
    assign irq        = (pend_a[0] && ien_q[0]) || (pend_a[1] && ien_q[1]);

endmodule

// File: rtl/cq_index_chk.sv
module cq_index_chk
    import cq_index_pkg::*;
#(
    parameter int RXC_DEPTH   = 16,
    parameter int TXC_DEPTH   = 8,
    parameter int TXD_DEPTH   = 8,
    parameter int TXD_BLOCKS  = 16,
    parameter int BLOCK_BYTES = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        rx_post,
    input logic        tx_post,
    input logic        reg_wr_en,
    input logic [1:0]  reg_addr,
    input logic [1:0]  reg_wr_half,
    input logic [31:0] reg_wdata,
    input logic        rx_pending,
    input logic        tx_pending,
    input logic        irq,
    input logic [15:0] tx_cmp_offset,
    input idx_t        rx_prod,
    input idx_t        rx_cons,
    input idx_t        tx_prod,
    input idx_t        tx_cons,
    input logic [1:0]  adv
);

    localparam idx_t RXM  = idx_t'(RXC_DEPTH - 1);
    localparam idx_t TXM  = idx_t'(TXC_DEPTH - 1);
    localparam idx_t STEP = idx_t'(TXD_BLOCKS * BLOCK_BYTES);
    localparam idx_t OFFM = idx_t'(TXD_DEPTH * TXD_BLOCKS * BLOCK_BYTES - 1);

    logic prod_wr_lo;
    logic prod_wr_hi;
    logic rx_full_c;
    logic tx_full_c;

    always_comb begin
        prod_wr_lo = reg_wr_en && (reg_addr == 2'd0) && reg_wr_half[0];
        prod_wr_hi = reg_wr_en && (reg_addr == 2'd0) && reg_wr_half[1];
        rx_full_c  = (idx_t'((rx_prod + idx_t'(1)) & RXM) == rx_cons);
        tx_full_c  = (idx_t'((tx_prod + idx_t'(1)) & TXM) == tx_cons);
    end

    p_rx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_post && !rx_full_c && !prod_wr_lo) |=>
            (rx_prod == idx_t'(($past(rx_prod) + idx_t'(1)) & RXM)));

    p_tx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_post && !tx_full_c && !prod_wr_hi) |=>
            (tx_prod == idx_t'(($past(tx_prod) + idx_t'(1)) & TXM)));

    p_adv_rx_r2: assert property (@(posedge clk) disable iff (rst)
        adv[0] |-> rx_post);

    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_post && rx_full_c && !prod_wr_lo) |=> (rx_prod == $past(rx_prod)));

    p_cons_keep_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd1 && reg_wr_half == 2'b01) |=>
            (tx_cons == $past(tx_cons)));

    p_cons_keep_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd1 && reg_wr_half == 2'b10) |=>
            (rx_cons == $past(rx_cons)));

    p_zero_prod_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == 2'd0 && reg_wr_half == 2'b11 && reg_wdata == 32'd0) |=>
            (rx_prod == '0 && tx_prod == '0 && tx_cmp_offset == '0));

    p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rx_pending || tx_pending));

    p_cmp_step_r9: assert property (@(posedge clk) disable iff (rst)
        (adv[1] && !prod_wr_hi) |=>
            (tx_cmp_offset == idx_t'(($past(tx_cmp_offset) + STEP) & OFFM)));

endmodule

bind cq_index_mgr cq_index_chk #(
    .RXC_DEPTH   (RXC_DEPTH),
    .TXC_DEPTH   (TXC_DEPTH),
    .TXD_DEPTH   (TXD_DEPTH),
    .TXD_BLOCKS  (TXD_BLOCKS),
    .BLOCK_BYTES (BLOCK_BYTES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .rx_post       (rx_post),
    .tx_post       (tx_post),
    .reg_wr_en     (reg_wr_en),
    .reg_addr      (reg_addr),
    .reg_wr_half   (reg_wr_half),
    .reg_wdata     (reg_wdata),
    .rx_pending    (rx_pending),
    .tx_pending    (tx_pending),
    .irq           (irq),
    .tx_cmp_offset (tx_cmp_offset),
    .rx_prod       (rx_prod),
    .rx_cons       (rx_cons),
    .tx_prod       (tx_prod),
    .tx_cons       (tx_cons),
    .adv           (adv_a)
);

// File: tb/tb_cq_index_mgr.sv
module tb_cq_index_mgr;

    localparam int RD  = 8;
    localparam int TD  = 4;
    localparam int XD  = 4;
    localparam int BLK = 16;
    localparam int BB  = 8;
    localparam int DESC_BYTES = BLK * BB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_post = 1'b0;
    logic        tx_post = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [1:0]  reg_wr_half = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        rx_pending;
    logic        tx_pending;
    logic        irq;
    logic [15:0] txd_prod_offset;
    logic [15:0] tx_cmp_offset;

    int checks = 0;
    int failures = 0;

    int m_rxp = 0, m_rxc = 0, m_txp = 0, m_txc = 0;
    int m_blk = 0, m_en = 0, m_done = 0;

    always #10 clk = ~clk;

    cq_index_mgr #(
        .RXC_DEPTH   (RD),
        .TXC_DEPTH   (TD),
        .TXD_DEPTH   (XD),
        .TXD_BLOCKS  (BLK),
        .BLOCK_BYTES (BB)
    ) dut (
        .clk             (clk),
        .rst             (rst),
        .rx_post         (rx_post),
        .tx_post         (tx_post),
        .reg_wr_en       (reg_wr_en),
        .reg_addr        (reg_addr),
        .reg_wr_half     (reg_wr_half),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .rx_pending      (rx_pending),
        .tx_pending      (tx_pending),
        .irq             (irq),
        .txd_prod_offset (txd_prod_offset),
        .tx_cmp_offset   (tx_cmp_offset)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // Compares every output with the model; tag names the phase requirement.
    task automatic check_all(input string tag);
        logic rp, tp, ir;
        rp = (m_rxp != m_rxc);
        tp = (m_txp != m_txc);
        ir = (rp && m_en[0]) || (tp && m_en[1]);
        reg_addr = 2'd0; #1;
        chk({tag, "/R2"}, "producer reg", reg_rdata, {16'(m_txp), 16'(m_rxp)});
        reg_addr = 2'd1; #1;
        chk({tag, "/R4"}, "consumer reg", reg_rdata, {16'(m_txc), 16'(m_rxc)});
        reg_addr = 2'd2; #1;
        chk({tag, "/R8"}, "txd reg", reg_rdata, {16'(m_blk), 16'h0});
        reg_addr = 2'd3; #1;
        chk({tag, "/R10"}, "enable reg", reg_rdata, 32'(m_en));
        chk({tag, "/R6"}, "rx_pending", 32'(rx_pending), 32'(rp));
        chk({tag, "/R6"}, "tx_pending", 32'(tx_pending), 32'(tp));
        chk({tag, "/R7"}, "irq", 32'(irq), 32'(ir));
        chk({tag, "/R8"}, "txd_prod_offset", 32'(txd_prod_offset), 32'(m_blk * BB));
        chk({tag, "/R9"}, "tx_cmp_offset", 32'(tx_cmp_offset), 32'(m_done));
    endtask

    // One clock cycle of stimulus, called just after a falling edge.
    task automatic cycle(input string tag, input logic rx, input logic tx,
                         input logic we, input logic [1:0] addr,
                         input logic [1:0] half, input logic [31:0] wd);
        int nrxp, nrxc, ntxp, ntxc, nblk, nen, ndone;
        logic rfull, tfull;
        rfull = (((m_rxp + 1) % RD) == m_rxc);
        tfull = (((m_txp + 1) % TD) == m_txc);
        nrxp = m_rxp; nrxc = m_rxc; ntxp = m_txp; ntxc = m_txc;
        nblk = m_blk; nen = m_en; ndone = m_done;
        if (we && addr == 2'd0 && half[0]) nrxp = int'(wd[15:0]) % RD;
        else if (rx && !rfull) nrxp = (m_rxp + 1) % RD;
        if (we && addr == 2'd0 && half[1]) begin
            ntxp = int'(wd[31:16]) % TD;
            ndone = 0;
        end else if (tx && !tfull) begin
            ntxp = (m_txp + 1) % TD;
            ndone = (m_done + DESC_BYTES) % (XD * DESC_BYTES);
        end
        if (we && addr == 2'd1 && half[0]) nrxc = int'(wd[15:0]) % RD;
        if (we && addr == 2'd1 && half[1]) ntxc = int'(wd[31:16]) % TD;
        if (we && addr == 2'd2) nblk = int'(wd[31:16]) % (XD * BLK);
        if (we && addr == 2'd3) nen = int'(wd[1:0]);
        rx_post = rx; tx_post = tx; reg_wr_en = we;
        reg_addr = addr; reg_wr_half = half; reg_wdata = wd;
        @(posedge clk);
        m_rxp = nrxp; m_rxc = nrxc; m_txp = ntxp; m_txc = ntxc;
        m_blk = nblk; m_en = nen; m_done = ndone;
        @(negedge clk);
        rx_post = 1'b0; tx_post = 1'b0; reg_wr_en = 1'b0;
        reg_wr_half = 2'd0; reg_wdata = 32'd0;
        check_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // Enable both interrupt sources (R10 write path)
        cycle("R10", 1'b0, 1'b0, 1'b1, 2'd3, 2'b00, 32'hFFFF_FFFD);
        cycle("R10", 1'b0, 1'b0, 1'b1, 2'd3, 2'b00, 32'h0000_0003);

        // Fill both rings, with both strobes together on alternate cycles; overflow drops (R3)
        for (int k = 0; k < 12; k++)
            cycle(k < 7 ? "R2" : "R3", 1'b1, k[0], 1'b0, 2'd0, 2'b00, 32'd0);

        // Consumer half writes: low only, then high only with masking (R4)
        cycle("R4", 1'b0, 1'b0, 1'b1, 2'd1, 2'b01, 32'h0003_0005);
        cycle("R4", 1'b0, 1'b0, 1'b1, 2'd1, 2'b10, 32'h0006_0001);
        cycle("R4", 1'b0, 1'b0, 1'b1, 2'd1, 2'b11, 32'hFFFF_FFFF);

        // Mixed posting with periodic draining (R6)
        for (int k = 0; k < 24; k++) begin
            if (k % 5 == 4)
                cycle("R6", 1'b0, k[0], 1'b1, 2'd1, 2'b11, {16'(m_txp), 16'(m_rxp)});
            else
                cycle("R6", (k % 3) != 0, k[0], 1'b0, 2'd0, 2'b00, 32'd0);
        end

        // Interrupt enable combinations with one ring pending (R7)
        cycle("R7", 1'b1, 1'b0, 1'b0, 2'd0, 2'b00, 32'd0);
        for (int e = 0; e < 4; e++)
            cycle("R7", 1'b0, 1'b0, 1'b1, 2'd3, 2'b00, 32'(e));
        cycle("R7", 1'b0, 1'b1, 1'b1, 2'd1, 2'b01, {16'h0, 16'(m_rxp)});
        for (int e = 0; e < 4; e++)
            cycle("R7", 1'b0, 1'b0, 1'b1, 2'd3, 2'b00, 32'(e));

        // Producer write beats simultaneous posts; then zero both registers (R5)
        cycle("R5", 1'b1, 1'b1, 1'b1, 2'd0, 2'b11, 32'h0002_0003);
        cycle("R5", 1'b1, 1'b1, 1'b1, 2'd0, 2'b01, 32'h0000_000E);
        cycle("R5", 1'b0, 1'b0, 1'b1, 2'd0, 2'b11, 32'h0000_0000);
        cycle("R5", 1'b0, 1'b0, 1'b1, 2'd1, 2'b11, 32'h0000_0000);

        // Descriptor block-count sweep, descriptor i written as i<<20 (R8)
        for (int i = 0; i <= XD; i++)
            cycle("R8", 1'b0, 1'b0, 1'b1, 2'd2, 2'b00, (32'(i) << 20) | 32'h0000_ABCD);
        cycle("R8", 1'b0, 1'b0, 1'b1, 2'd2, 2'b01, 32'h0005_0000);
        cycle("R8", 1'b0, 1'b0, 1'b1, 2'd2, 2'b10, 32'hFFFF_0000);

        // Completion byte offset sweep through several wraps, draining each cycle (R9)
        for (int k = 0; k < 2 * XD + 3; k++)
            cycle("R9", 1'b0, 1'b1, 1'b1, 2'd1, 2'b10, {16'(m_txp), 16'h0});
        cycle("R9", 1'b0, 1'b1, 1'b1, 2'd0, 2'b10, 32'h0001_0000);
        cycle("R9", 1'b0, 1'b1, 1'b0, 2'd0, 2'b00, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule